// File: doc/BRIEF.md
# ATA Programmed I/O Cycle Timer

This block runs host-side programmed I/O cycles on a 16-bit ATA device bus. An internal requester offers one access at a time: read or write, a 3-bit register address, two chip-select bits and a flag marking the access as a 16-bit data transfer or an 8-bit register transfer. The block drives the address and active-low chip selects. It pulses the active-low read or write strobe, drives write data with an output enable, and captures read data from the bus.

Each access passes through four phases: address setup, strobe, hold and recovery. The minimum length of each phase comes from the transfer mode (0 to 4) presented with the request. Every nanosecond limit becomes a clock count by rounding up against the clock period parameter, which defaults to about 60 MHz. The device ready line can stretch the strobe. Modes 3 and 4 always honour it, and modes 0 to 2 honour it only when an enable input is set. A strobe that is held too long is cut off and the access is flagged. A single-cycle done pulse returns the result.

Top module: `ata_pio_timer`

## Requirements
- R1: After reset the block is idle with req_ready 1, done 0, timeout 0, both strobes high, cs_n = 2'b11 and dd_oe 0.
- R2: After a request is accepted, da and cs_n (cs_n = ~req_cs) are driven for ceil(Ts/Tclk) cycles before the strobe falls, where Ts is 70, 50, 30, 30 and 25 ns for modes 0..4.
- R3: For a 16-bit access (req_wide = 1) with ready not in use, the strobe stays low for ceil(Tp/Tclk) cycles, where Tp is 165, 125, 100, 80 and 70 ns for modes 0..4.
- R4: For an 8-bit access (req_wide = 0) the minimum strobe is 290 ns in modes 0..2 and 80 and 70 ns in modes 3 and 4, rounded up to cycles.
- R5: After the strobe rises, da and cs_n stay driven for ceil(Th/Tclk) cycles, where Th is the larger of the address hold (20, 15, 10, 10, 10 ns) and the write data hold (30, 20, 15, 10, 10 ns) for modes 0..4.
- R6: After the hold phase, cs_n is released to 2'b11 for max(Rmin, ceil(T0/Tclk) - setup - minimum strobe - hold) cycles before done. T0 is 600, 383, 240, 180 and 120 ns for modes 0..4. Rmin is 1 cycle in modes 0..2 and ceil(70 ns) and ceil(25 ns) in modes 3 and 4. The four phases together span at least ceil(T0/Tclk) cycles.
- R7: A read pulses dior_n and returns, on rdata with done, the dd_in value sampled in the last strobe cycle. rdata holds that value after the cycle.
- R8: A write pulses diow_n with dior_n kept high and drives dd_out = req_wdata with dd_oe = 1 through the setup, strobe and hold phases. At no time are both strobes low together.
- R9: When ready is in use (modes 3 and 4, or modes 0..2 with rdy_en_slow = 1), a strobe that has reached its minimum length ends at the first clock edge that samples iordy high.
- R10: In modes 0..2 with rdy_en_slow = 0, iordy is ignored. The strobe keeps its minimum length even if iordy is held low, and timeout stays 0.
- R11: If ready is in use and iordy stays low, the strobe ends after ceil(1250 ns/Tclk) cycles, and timeout is 1 in the same cycle as done.
- R12: done is high for exactly one cycle per access. req_ready is 0 while an access runs, and a request offered then is dropped and never starts a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit data access, 0 = 8-bit register access |
| req_addr | input | 3 | Register address |
| req_cs | input | 2 | Chip selects, active high |
| req_wdata | input | 16 | Write data |
| mode | input | 3 | Transfer mode 0..4, sampled at accept |
| rdy_en_slow | input | 1 | Honour iordy in modes 0..2 |
| req_ready | output | 1 | Idle and able to accept |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Ready limit hit, valid with done |
| rdata | output | 16 | Captured read data |
| da | output | 3 | Device address |
| cs_n | output | 2 | Device chip selects, active low |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| dd_out | output | 16 | Write data to the bus |
| dd_oe | output | 1 | Bus output enable |
| dd_in | input | 16 | Read data from the bus |
| iordy | input | 1 | Device ready |

## Verification
Reads in all five modes measure each phase length on its own. This separates the setup, strobe, hold and recovery counts, which a single total would merge. The same mode run with 8-bit and 16-bit widths tells the two strobe tables apart, and a write checks the strobe choice and the bus enable. iordy is then held low or raised late with ready enabled, ignored, and never released. These three patterns separate stretching, the slow-mode enable and the timeout cut-off. A request offered mid-strobe shows that busy requests are dropped.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

    parameter int NMODES = 5;
    parameter int CNT_W  = 8;
    parameter int DATA_W = 16;
    parameter int ADDR_W = 3;
    parameter int CS_W   = 2;
    parameter int MODE_W = 3;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_RECOV
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] pulse;
        logic [CNT_W-1:0] hold;
        logic [CNT_W-1:0] recov;
    } tim_t;

    typedef struct packed {
        logic              wr;
        logic              wide;
        logic              rdy;
        logic [MODE_W-1:0] mode;
        logic [ADDR_W-1:0] addr;
        logic [CS_W-1:0]   cs;
        logic [DATA_W-1:0] wdata;
    } req_t;

    localparam int NS_CYCLE [NMODES] = '{600, 383, 240, 180, 120};
    localparam int NS_SETUP [NMODES] = '{70, 50, 30, 30, 25};
    localparam int NS_PW16  [NMODES] = '{165, 125, 100, 80, 70};
    localparam int NS_PW8   [NMODES] = '{290, 290, 290, 80, 70};
    localparam int NS_RECMIN[NMODES] = '{0, 0, 0, 70, 25};
    localparam int NS_AHOLD [NMODES] = '{20, 15, 10, 10, 10};
    localparam int NS_WHOLD [NMODES] = '{30, 20, 15, 10, 10};

    function automatic int ns_to_cyc(int ns, int clk_ps);
        return (ns * 1000 + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ata_pio_timing.sv
module ata_pio_timing
    import ata_pio_pkg::*;
#(
    parameter int CLK_PS = 16667
) (
    input  logic [MODE_W-1:0] mode,
    input  logic              wide,
    output tim_t              tim
);

    tim_t tab16 [NMODES];
    tim_t tab8  [NMODES];

    for (genvar m = 0; m < NMODES; m++) begin : g_mode
        localparam int S   = imax(1, ns_to_cyc(NS_SETUP[m], CLK_PS));
        localparam int P16 = imax(1, ns_to_cyc(NS_PW16[m], CLK_PS));
        localparam int P8  = imax(1, ns_to_cyc(NS_PW8[m], CLK_PS));
        localparam int H   = imax(1, ns_to_cyc(imax(NS_AHOLD[m], NS_WHOLD[m]), CLK_PS));
        localparam int T0  = ns_to_cyc(NS_CYCLE[m], CLK_PS);
        localparam int RM  = imax(1, ns_to_cyc(NS_RECMIN[m], CLK_PS));
        localparam int R16 = imax(RM, T0 - S - P16 - H);
        localparam int R8  = imax(RM, T0 - S - P8 - H);

        assign tab16[m] = '{setup: CNT_W'(S), pulse: CNT_W'(P16),
                            hold: CNT_W'(H), recov: CNT_W'(R16)};
        assign tab8[m]  = '{setup: CNT_W'(S), pulse: CNT_W'(P8),
                            hold: CNT_W'(H), recov: CNT_W'(R8)};
    end

    int idx;
    always_comb begin
        idx = (int'(mode) < NMODES) ? int'(mode) : 0;
        tim = wide ? tab16[idx] : tab8[idx];
    end

endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
    import ata_pio_pkg::*;
#(
    parameter int TO_CYC = 75
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  tim_t   tim,
    input  logic   rdy_used,
    input  logic   iordy,
    output phase_e phase,
    output logic   capture,
    output logic   done,
    output logic   timeout
);

    localparam logic [CNT_W-1:0] TO_LAST = CNT_W'(TO_CYC - 1);

    logic [CNT_W-1:0] cnt;
    logic             to_q;
    logic             strobe_end;

    always_comb begin
        strobe_end = (phase == PH_STROBE) &&
                     (((cnt >= tim.pulse - 1'b1) && (!rdy_used || iordy)) ||
                      (cnt >= TO_LAST));
        capture = strobe_end;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            to_q    <= 1'b0;
            done    <= 1'b0;
            timeout <= 1'b0;
        end else begin
            done    <= 1'b0;
            timeout <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_SETUP;
                        cnt   <= '0;
                    end
                end
                PH_SETUP: begin
                    if (cnt == tim.setup - 1'b1) begin
                        phase <= PH_STROBE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (strobe_end) begin
                        phase <= PH_HOLD;
                        cnt   <= '0;
                        to_q  <= rdy_used && !iordy;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (cnt == tim.hold - 1'b1) begin
                        phase <= PH_RECOV;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_RECOV: begin
                    if (cnt == tim.recov - 1'b1) begin
                        phase   <= PH_IDLE;
                        cnt     <= '0;
                        done    <= 1'b1;
                        timeout <= to_q;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R12
    AST_TIMEOUT_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        timeout |-> done); // R11
    AST_STRETCH_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STROBE) |-> (cnt < CNT_W'(TO_CYC))); // R11
    AST_HOLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HOLD && $past(phase) != PH_HOLD) |-> ($past(phase) == PH_STROBE)); // R5
    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SETUP && $past(phase) != PH_SETUP) |-> ($past(phase) == PH_IDLE)); // R12

endmodule

// File: rtl/ata_pio_timer.sv
module ata_pio_timer
    import ata_pio_pkg::*;
#(
    parameter int CLK_PS       = 16667,
    parameter int READY_MAX_NS = 1250
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [MODE_W-1:0] mode,
    input  logic              rdy_en_slow,
    output logic              req_ready,
    output logic              done,
    output logic              timeout,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] da,
    output logic [CS_W-1:0]   cs_n,
    output logic              dior_n,
    output logic              diow_n,
    output logic [DATA_W-1:0] dd_out,
    output logic              dd_oe,
    input  logic [DATA_W-1:0] dd_in,
    input  logic              iordy
);

    localparam int TO_CYC = imax(1, ns_to_cyc(READY_MAX_NS, CLK_PS));

    req_t   req_q;
    tim_t   tim;
    phase_e phase;
    logic   start;
    logic   capture;
    logic   rdy_used;
    logic   bus_active;
    logic   strobing;

    assign req_ready = (phase == PH_IDLE);
    assign start     = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (start) begin
            req_q.wr    <= req_write;
            req_q.wide  <= req_wide;
            req_q.rdy   <= rdy_en_slow;
            req_q.mode  <= (int'(mode) < NMODES) ? mode : '0;
            req_q.addr  <= req_addr;
            req_q.cs    <= req_cs;
            req_q.wdata <= req_wdata;
        end
    end

    assign rdy_used = req_q.rdy || (req_q.mode >= MODE_W'(3));

    ata_pio_timing #(.CLK_PS(CLK_PS)) i_timing (
        .mode (req_q.mode),
        .wide (req_q.wide),
        .tim  (tim)
    );

    ata_pio_seq #(.TO_CYC(TO_CYC)) i_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .tim      (tim),
        .rdy_used (rdy_used),
        .iordy    (iordy),
        .phase    (phase),
        .capture  (capture),
        .done     (done),
        .timeout  (timeout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (capture && !req_q.wr) begin
            rdata <= dd_in;
        end
    end

    always_comb begin
        bus_active = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
        strobing   = (phase == PH_STROBE);
        da         = bus_active ? req_q.addr : '0;
        cs_n       = bus_active ? ~req_q.cs : '1;
        dior_n     = !(strobing && !req_q.wr);
        diow_n     = !(strobing && req_q.wr);
        dd_oe      = bus_active && req_q.wr;
        dd_out     = req_q.wdata;
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({!dior_n, !diow_n})); // R8
    AST_OE_NOT_READ: assert property (@(posedge clk) disable iff (rst)
        dd_oe |-> dior_n); // R8
    AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (rst)
        (!dior_n || !diow_n) |-> !req_ready); // R12

endmodule

// File: tb/test_ata_pio_timer.sv
module test_ata_pio_timer;
    localparam int CPS = 20000;
    localparam int NEVER = 1000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b1;
    logic [2:0] req_addr = '0;
    logic [1:0] req_cs = '0;
    logic [15:0] req_wdata = '0;
    logic [2:0] mode = '0;
    logic rdy_en_slow = 1'b0;
    logic req_ready, done, timeout, dior_n, diow_n, dd_oe;
    logic [15:0] rdata, dd_out;
    logic [15:0] dd_in = '0;
    logic [2:0] da;
    logic [1:0] cs_n;
    logic iordy = 1'b1;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ata_pio_timer #(.CLK_PS(CPS)) i_ata_pio_timer (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_wide(req_wide), .req_addr(req_addr), .req_cs(req_cs),
        .req_wdata(req_wdata), .mode(mode), .rdy_en_slow(rdy_en_slow),
        .req_ready(req_ready), .done(done), .timeout(timeout), .rdata(rdata),
        .da(da), .cs_n(cs_n), .dior_n(dior_n), .diow_n(diow_n),
        .dd_out(dd_out), .dd_oe(dd_oe), .dd_in(dd_in), .iordy(iordy)
    );

    function automatic int cyc(int ns);
        return (ns * 1000 + CPS - 1) / CPS;
    endfunction
    function automatic int mx(int a, int b);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic xfer(input string tag, input bit wr, input bit wide, input bit en,
                        input int md, input logic [2:0] ad, input logic [1:0] cs,
                        input logic [15:0] val, input int k, input bit poke);
        int t0s [5] = '{600, 383, 240, 180, 120};
        int sus [5] = '{70, 50, 30, 30, 25};
        int p16 [5] = '{165, 125, 100, 80, 70};
        int p8  [5] = '{290, 290, 290, 80, 70};
        int ahd [5] = '{20, 15, 10, 10, 10};
        int whd [5] = '{30, 20, 15, 10, 10};
        int s = 0, p = 0, h = 0, r = 0, wd = 0, bad = 0;
        int es, ep, eh, er, rmin, ap, eto;
        bit rdy, seen = 0;
        es = cyc(sus[md]);
        ep = wide ? cyc(p16[md]) : cyc(p8[md]);
        eh = cyc(mx(ahd[md], whd[md]));
        rmin = (md == 3) ? cyc(70) : (md == 4) ? cyc(25) : 1;
        er = mx(rmin, cyc(t0s[md]) - es - ep - eh);
        rdy = en || (md >= 3);
        ap = ep; eto = 0;
        if (rdy && k == NEVER) begin ap = cyc(1250); eto = 1; end
        else if (rdy && k > 0) ap = mx(ep, k);

        @(negedge clk);
        req_write = wr; req_wide = wide; rdy_en_slow = en; mode = 3'(md);
        req_addr = ad; req_cs = cs; req_wdata = val; req_valid = 1'b1;
        iordy = (k == 0); dd_in = val;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && wd < 500) begin
            wd++;
            if ((wr ? !diow_n : !dior_n)) begin
                p++;
                if (da != ad || cs_n != ~cs) bad++;
                if (wr && (!dd_oe || dd_out != val || !dior_n)) bad++;
                if (p == k) iordy = 1'b1;
            end else if (cs_n != 2'b11) begin
                if (p == 0) s++;
                else begin h++; dd_in = ~val; end
                if (da != ad) bad++;
                if (wr && (!dd_oe || dd_out != val)) bad++;
            end else if (p > 0) r++;
            if (!wr && !diow_n) bad++;
            if (poke && p == 1 && !dior_n) begin
                chk({tag, " R12 busy req_ready"}, int'(req_ready), 0);
                req_addr = 3'd7; req_valid = 1'b1;
            end else req_valid = 1'b0;
            @(negedge clk);
        end
        seen = done;
        chk({tag, " done seen R12"}, int'(seen), 1);
        chk({tag, " setup R2"}, s, es);
        chk({tag, " strobe R3 R4 R9 R10 R11"}, p, ap);
        chk({tag, " hold R5"}, h, eh);
        chk({tag, " recovery R6"}, r, er);
        chk({tag, " cycle total R6"}, int'(s + ep + h + r >= cyc(t0s[md])), 1);
        chk({tag, " bus values R2 R8"}, bad, 0);
        chk({tag, " timeout R11"}, int'(timeout), eto);
        if (!wr) chk({tag, " rdata R7"}, int'(rdata), int'(val));
        iordy = 1'b1;
        @(negedge clk);
        chk({tag, " done single R12"}, int'(done), 0);
        if (!wr) chk({tag, " rdata held R7"}, int'(rdata), int'(val));
        if (poke) begin
            repeat (3) begin
                chk({tag, " dropped request R12"}, int'(cs_n == 2'b11 && dior_n && diow_n), 1);
                @(negedge clk);
            end
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 req_ready", int'(req_ready), 1);
        chk("R1 done", int'(done), 0);
        chk("R1 timeout", int'(timeout), 0);
        chk("R1 strobes", int'({dior_n, diow_n}), 3);
        chk("R1 cs_n", int'(cs_n), 3);
        chk("R1 dd_oe", int'(dd_oe), 0);
    endtask

    task automatic t_read_modes;
        for (int m = 0; m < 5; m++)
            xfer($sformatf("rd16 m%0d", m), 0, 1, 0, m, 3'(m + 1), 2'b01,
                 16'(16'h1234 + m * 16'h1111), 0, 0);
    endtask

    task automatic t_narrow;
        xfer("rd8 m0 R4", 0, 0, 0, 0, 3'd7, 2'b10, 16'h00A5, 0, 0);
        xfer("rd8 m2 R4", 0, 0, 0, 2, 3'd1, 2'b10, 16'h005A, 0, 0);
        xfer("rd8 m3 R4", 0, 0, 0, 3, 3'd6, 2'b01, 16'h00C3, 0, 0);
    endtask

    task automatic t_write;
        xfer("wr16 m1 R8", 1, 1, 0, 1, 3'd0, 2'b01, 16'hBEEF, 0, 0);
        xfer("wr8 m4 R8", 1, 0, 0, 4, 3'd5, 2'b10, 16'h0033, 0, 0);
    endtask

    task automatic t_stretch;
        xfer("stretch m3 R9", 0, 1, 0, 3, 3'd2, 2'b01, 16'h4321, 10, 0);
        xfer("stretch m1 en R9", 0, 1, 1, 1, 3'd3, 2'b01, 16'h8765, 12, 0);
        xfer("early ready m4 R9", 0, 1, 0, 4, 3'd4, 2'b01, 16'h0F0F, 2, 0);
    endtask

    task automatic t_ignore;
        xfer("ignored m1 R10", 0, 1, 0, 1, 3'd2, 2'b01, 16'hA0A0, NEVER, 0);
    endtask

    task automatic t_timeout;
        xfer("timeout m4 R11", 0, 1, 0, 4, 3'd1, 2'b01, 16'h5555, NEVER, 0);
        xfer("after timeout m4 R11", 0, 1, 0, 4, 3'd1, 2'b01, 16'h6666, 0, 0);
    endtask

    task automatic t_busy;
        xfer("busy m2 R12", 0, 1, 0, 2, 3'd3, 2'b01, 16'h7777, 0, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_read_modes();
        t_narrow();
        t_write();
        t_stretch();
        t_ignore();
        t_timeout();
        t_busy();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule